// File: doc/BRIEF.md
# Switch Control Port: CPU Register and Memory Access

This block is the host-side access unit of a time-slot interchange switch. A host processor with an 8-bit data bus and no common clock reaches the switch through a strobed, asynchronous port. The port has a 6-bit address, an active-low select, an active-high strobe, a direction line and an active-low acknowledge. The top address bit picks between a single paging register and a 32-location window. The paging register names a stream and a target memory, and the window then covers that stream's 32 channel locations in the chosen memory.

The block holds the per-channel connection memory: a low byte and a high byte for every output slot. The serial datapath reads this memory through its own port every slot, and that read always wins. Host accesses to the connection memory wait for a cycle with no datapath read, so a slot read never sees a half-finished update. The data memory stays in the datapath and is read through a request/address/data port. The paging register also exports the force-all-to-processor-mode flag, and it has a split mode in which host reads come from the data memory while host writes go to the connection memory.

Top module: `tsi_cpu_access`

## Requirements
- R1: After reset, `cpu_ack_n` is 1, `cpu_rdata_oe` is 0, `proc_force` is 0 and the paging register reads back 8'h00.
- R2: With `cpu_addr[5]`=0 the access targets the paging register: a write stores all 8 bits, a read returns them, and `proc_force` follows bit 6.
- R3: With `cpu_addr[5]`=1 the connection-memory location is {paging bits 2..0, `cpu_addr[4:0]`}, so location = stream*32 + channel.
- R4: Paging bits 4..3 select the target: 2'b10 is the connection low byte, 2'b11 is the connection high byte, and 2'b00 and 2'b01 are the data memory. The two connection bytes are written independently.
- R5: A host read of a connection byte returns the value last written to that location.
- R6: A host read that targets the data memory drives `dm_rd_en` with `dm_raddr` = stream*32+channel and returns `dm_rdata`. A host write that targets the data memory is acknowledged and changes no connection byte.
- R7: When paging bit 7 (split) is 1, every window read returns the data memory, and window writes still go to the connection byte chosen by bits 4..3.
- R8: An access starts only while `cpu_cs_n`=0 and `cpu_ds`=1. A strobe with the select high, or a select without the strobe, produces no acknowledge and changes no state.
- R9: `cpu_ack_n` falls only after a read value is latched or a write is committed, stays low while the strobe is held, and rises within SYNC_STAGES+3 clocks after the strobe is removed.
- R10: Datapath reads have priority. A host connection-memory access is held pending while `dp_rd_en` is 1 and completes once a free cycle occurs.
- R11: `cpu_rdata_oe` is 1 only while the acknowledge is low for a read access.
- R12: A datapath read with `dp_rd_en`=1 returns both bytes of location `dp_rd_addr` on `dp_cm_lo`/`dp_cm_hi`, with `dp_valid`=1, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs_n | input | 1 | Host select, active low |
| cpu_ds | input | 1 | Host data strobe, active high |
| cpu_rw | input | 1 | Direction: 1 read, 0 write |
| cpu_addr | input | 6 | Bit 5 picks window (1) or paging register (0); bits 4..0 channel |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Host read data |
| cpu_rdata_oe | output | 1 | Host data bus drive enable |
| cpu_ack_n | output | 1 | Transfer acknowledge, active low (open-drain pull-down) |
| proc_force | output | 1 | Forces every output slot into processor mode |
| dm_rd_en | output | 1 | Data memory read request |
| dm_raddr | output | 8 | Data memory read address |
| dm_rdata | input | 8 | Data memory read data, sampled the clock after the request |
| dp_rd_en | input | 1 | Datapath connection-memory read |
| dp_rd_addr | input | 8 | Datapath read location |
| dp_cm_lo | output | 8 | Connection low byte read result |
| dp_cm_hi | output | 8 | Connection high byte read result |
| dp_valid | output | 1 | Datapath read result valid |

## Verification
The hardest state to reach from the ports is a host connection-memory access that sits pending behind datapath reads. The datapath reads are what real traffic produces, and they only occasionally collide with the host. The bench holds `dp_rd_en` high for a long stretch while a host write is strobed and checks that no acknowledge appears. It then drops the datapath reads and checks that the write completes. The full 256-location sweeps of both connection bytes run with a periodic background datapath read stream, so host accesses keep being deferred at many different phases.

// File: rtl/tsi_cpu_pkg.sv
package tsi_cpu_pkg;

  typedef enum logic [1:0] {
    T_NONE = 2'd0,
    T_DM   = 2'd1,
    T_CML  = 2'd2,
    T_CMH  = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DEC   = 3'd1,
    S_DM    = 3'd2,
    S_DMCAP = 3'd3,
    S_CMREQ = 3'd4,
    S_CMCAP = 3'd5,
    S_HOLD  = 3'd6,
    S_ACK   = 3'd7
  } seq_e;

  // paging register field helpers
  function automatic logic pg_split(input logic [7:0] c);
    return c[7];
  endfunction

  function automatic logic pg_force(input logic [7:0] c);
    return c[6];
  endfunction

  function automatic logic [1:0] pg_sel(input logic [7:0] c);
    return c[4:3];
  endfunction

  // target memory for a window access
  function automatic tgt_e pick_target(input logic [7:0] c, input logic is_rd);
    tgt_e t;
    if (is_rd && pg_split(c)) begin
      t = T_DM;
    end else begin
      case (pg_sel(c))
        2'b10:   t = T_CML;
        2'b11:   t = T_CMH;
        default: t = is_rd ? T_DM : T_NONE;
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/tsi_cpu_sync.sv
module tsi_cpu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/tsi_cpu_cm.sv
module tsi_cpu_cm #(
  parameter int DW  = 8,
  parameter int MAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dp_rd_en,
  input  logic [MAW-1:0] dp_rd_addr,
  output logic [DW-1:0]  dp_cm_lo,
  output logic [DW-1:0]  dp_cm_hi,
  output logic           dp_valid,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic           cpu_hi,
  input  logic [MAW-1:0] cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic           cpu_gnt,
  output logic [DW-1:0]  cpu_rdata
);
  localparam int DEPTH = 1 << MAW;

  logic [DW-1:0] dp_q  [2];
  logic [DW-1:0] cpu_q [2];
  logic          hi_q;

  // datapath owns the array whenever it reads
  assign cpu_gnt = cpu_req && !dp_rd_en;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          sel_b;
    assign sel_b = (b == 1) ? cpu_hi : !cpu_hi;

    always_ff @(posedge clk) begin
      if (dp_rd_en) dp_q[b] <= mem[dp_rd_addr];
      if (cpu_gnt && sel_b) begin
        if (cpu_we) mem[cpu_addr] <= cpu_wdata;
        else        cpu_q[b]      <= mem[cpu_addr];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      hi_q     <= 1'b0;
    end else begin
      dp_valid <= dp_rd_en;
      if (cpu_gnt) hi_q <= cpu_hi;
    end
  end

  assign dp_cm_lo  = dp_q[0];
  assign dp_cm_hi  = dp_q[1];
  assign cpu_rdata = hi_q ? cpu_q[1] : cpu_q[0];

  assert_dp_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rd_en |=> dp_valid);

endmodule

// File: rtl/tsi_cpu_seq.sv
module tsi_cpu_seq
  import tsi_cpu_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CH_BITS = 5,
  parameter int ST_BITS = 3,
  parameter int ACK_DLY = 2,
  localparam int AW     = CH_BITS + 1,
  localparam int MAW    = ST_BITS + CH_BITS,
  localparam int CW     = $clog2(ACK_DLY + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe_s,
  input  logic [AW-1:0]  cpu_addr,
  input  logic           cpu_rw,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           cpu_rdata_oe,
  output logic           cpu_ack_n,
  output logic [7:0]     ctrl,
  output logic           dm_rd_en,
  output logic [MAW-1:0] dm_raddr,
  input  logic [DW-1:0]  dm_rdata,
  output logic           cm_req,
  output logic           cm_we,
  output logic           cm_hi,
  output logic [MAW-1:0] cm_addr,
  output logic [DW-1:0]  cm_wdata,
  input  logic           cm_gnt,
  input  logic [DW-1:0]  cm_rdata
);
  seq_e          st;
  logic          strobe_d;
  logic          strobe_rise;
  logic [AW-1:0] addr_q;
  logic          rd_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rdata_q;
  logic [7:0]    ctrl_q;
  logic [MAW-1:0] win_q;
  tgt_e          tgt_q;
  logic [CW-1:0] cnt_q;
  logic          in_idle;

  assign strobe_rise = strobe_s && !strobe_d;
  assign in_idle     = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      strobe_d     <= 1'b0;
      addr_q       <= '0;
      rd_q         <= 1'b0;
      wd_q         <= '0;
      rdata_q      <= '0;
      ctrl_q       <= '0;
      win_q        <= '0;
      tgt_q        <= T_NONE;
      cnt_q        <= '0;
      cpu_ack_n    <= 1'b1;
      cpu_rdata_oe <= 1'b0;
    end else begin
      strobe_d <= strobe_s;
      case (st)
        S_IDLE: if (strobe_rise) begin
          addr_q <= cpu_addr;
          rd_q   <= cpu_rw;
          wd_q   <= cpu_wdata;
          st     <= S_DEC;
        end
        S_DEC: begin
          cnt_q <= '0;
          win_q <= {ctrl_q[ST_BITS-1:0], addr_q[CH_BITS-1:0]};
          if (!addr_q[AW-1]) begin
            if (rd_q) rdata_q <= ctrl_q[DW-1:0];
            else      ctrl_q  <= wd_q[7:0];
            st <= S_HOLD;
          end else begin
            tgt_q <= pick_target(ctrl_q, rd_q);
            case (pick_target(ctrl_q, rd_q))
              T_DM:    st <= S_DM;
              T_CML,
              T_CMH:   st <= S_CMREQ;
              default: st <= S_HOLD;
            endcase
          end
        end
        S_DM:    st <= S_DMCAP;
        S_DMCAP: begin
          rdata_q <= dm_rdata;
          st      <= S_HOLD;
        end
        S_CMREQ: if (cm_gnt) st <= rd_q ? S_CMCAP : S_HOLD;
        S_CMCAP: begin
          rdata_q <= cm_rdata;
          st      <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt_q == CW'(ACK_DLY - 1)) begin
            st           <= S_ACK;
            cpu_ack_n    <= 1'b0;
            cpu_rdata_oe <= rd_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_ACK: if (!strobe_s) begin
          st           <= S_IDLE;
          cpu_ack_n    <= 1'b1;
          cpu_rdata_oe <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ctrl      = ctrl_q;
  assign cpu_rdata = rdata_q;
  assign dm_rd_en  = (st == S_DM);
  assign dm_raddr  = win_q;
  assign cm_req    = (st == S_CMREQ);
  assign cm_we     = !rd_q;
  assign cm_hi     = (tgt_q == T_CMH);
  assign cm_addr   = win_q;
  assign cm_wdata  = wd_q;

  assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !strobe_s) |=> in_idle);

  assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ack_n && strobe_s) |=> !cpu_ack_n);

  assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> cpu_ack_n);

  assert_oe_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_oe |-> (!cpu_ack_n && rd_q));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_req && !cm_gnt) |=> cm_req);

endmodule

// File: rtl/tsi_cpu_access.sv
module tsi_cpu_access #(
  parameter int DW          = 8,
  parameter int CH_BITS     = 5,
  parameter int ST_BITS     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ACK_DLY     = 2,
  localparam int AW         = CH_BITS + 1,
  localparam int MAW        = ST_BITS + CH_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_cs_n,
  input  logic           cpu_ds,
  input  logic           cpu_rw,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           cpu_rdata_oe,
  output logic           cpu_ack_n,
  output logic           proc_force,
  output logic           dm_rd_en,
  output logic [MAW-1:0] dm_raddr,
  input  logic [DW-1:0]  dm_rdata,
  input  logic           dp_rd_en,
  input  logic [MAW-1:0] dp_rd_addr,
  output logic [DW-1:0]  dp_cm_lo,
  output logic [DW-1:0]  dp_cm_hi,
  output logic           dp_valid
);
  logic           strobe_raw;
  logic           strobe_s;
  logic [7:0]     ctrl;
  logic           cm_req, cm_we, cm_hi, cm_gnt;
  logic [MAW-1:0] cm_addr;
  logic [DW-1:0]  cm_wdata, cm_rdata;

  assign strobe_raw = !cpu_cs_n && cpu_ds;

  tsi_cpu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (strobe_raw), .q (strobe_s)
  );

  tsi_cpu_seq #(
    .DW (DW), .CH_BITS (CH_BITS), .ST_BITS (ST_BITS), .ACK_DLY (ACK_DLY)
  ) u_seq (
    .clk (clk), .rst_n (rst_n), .strobe_s (strobe_s),
    .cpu_addr (cpu_addr), .cpu_rw (cpu_rw), .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata), .cpu_rdata_oe (cpu_rdata_oe), .cpu_ack_n (cpu_ack_n),
    .ctrl (ctrl), .dm_rd_en (dm_rd_en), .dm_raddr (dm_raddr), .dm_rdata (dm_rdata),
    .cm_req (cm_req), .cm_we (cm_we), .cm_hi (cm_hi), .cm_addr (cm_addr),
    .cm_wdata (cm_wdata), .cm_gnt (cm_gnt), .cm_rdata (cm_rdata)
  );

  tsi_cpu_cm #(.DW (DW), .MAW (MAW)) u_cm (
    .clk (clk), .rst_n (rst_n),
    .dp_rd_en (dp_rd_en), .dp_rd_addr (dp_rd_addr),
    .dp_cm_lo (dp_cm_lo), .dp_cm_hi (dp_cm_hi), .dp_valid (dp_valid),
    .cpu_req (cm_req), .cpu_we (cm_we), .cpu_hi (cm_hi), .cpu_addr (cm_addr),
    .cpu_wdata (cm_wdata), .cpu_gnt (cm_gnt), .cpu_rdata (cm_rdata)
  );

  assign proc_force = tsi_cpu_pkg::pg_force(ctrl);

endmodule

// File: tb/tb_tsi_cpu_access.sv
module tb_tsi_cpu_access;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_cs_n = 1'b1, cpu_ds = 1'b0, cpu_rw = 1'b1;
  logic [5:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_rdata_oe, cpu_ack_n, proc_force, dm_rd_en, dp_valid;
  logic [7:0] dm_raddr, dm_rdata, dp_cm_lo, dp_cm_hi, dp_rd_addr;
  logic       dp_rd_en;

  logic       man_en = 1'b0, noise_en = 1'b0, busy_all = 1'b0;
  logic [7:0] man_addr = '0;
  logic [7:0] noise_addr = '0;
  logic [1:0] noise_ph = '0;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // data memory model: value derived from the location
  function automatic logic [7:0] dm_val(input logic [7:0] a);
    return 8'(a * 7 + 3);
  endfunction
  function automatic logic [7:0] lo_val(input int s, input int c);
    return 8'((s * 32 + c) ^ 8'h3C);
  endfunction
  function automatic logic [7:0] hi_val(input int s, input int c);
    return 8'(((s << 5) | c) * 5 + 1);
  endfunction
  function automatic logic [7:0] pg(input logic split, input logic frc,
                                    input logic [1:0] sel, input int s);
    return {split, frc, 1'b0, sel, 3'(s)};
  endfunction

  assign dm_rdata   = dm_val(dm_raddr);
  assign dp_rd_en   = man_en | busy_all | (noise_en & (noise_ph == 2'd0));
  assign dp_rd_addr = man_en ? man_addr : noise_addr;

  always @(negedge clk) begin
    noise_ph   <= noise_ph + 2'd1;
    noise_addr <= noise_addr + 8'd37;
  end

  tsi_cpu_access dut (
    .clk (clk), .rst_n (rst_n), .cpu_cs_n (cpu_cs_n), .cpu_ds (cpu_ds),
    .cpu_rw (cpu_rw), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata), .cpu_rdata_oe (cpu_rdata_oe), .cpu_ack_n (cpu_ack_n),
    .proc_force (proc_force), .dm_rd_en (dm_rd_en), .dm_raddr (dm_raddr),
    .dm_rdata (dm_rdata), .dp_rd_en (dp_rd_en), .dp_rd_addr (dp_rd_addr),
    .dp_cm_lo (dp_cm_lo), .dp_cm_hi (dp_cm_hi), .dp_valid (dp_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ack(output bit got);
    got = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cpu_ack_n == 1'b0) begin got = 1; break; end
    end
  endtask

  task automatic release_bus();
    int k;
    cpu_ds = 1'b0; cpu_cs_n = 1'b1;
    k = 0;
    while (cpu_ack_n !== 1'b1 && k < 40) begin @(negedge clk); k++; end
    check("R9 release", (k <= SYNC + 3), 1);
  endtask

  task automatic cpu_xfer(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                          output logic [7:0] rdv);
    bit got;
    @(negedge clk);
    cpu_rw = rd; cpu_addr = a; cpu_wdata = wd; cpu_cs_n = 1'b0; cpu_ds = 1'b1;
    wait_ack(got);
    check("R9 ack", got, 1);
    check("R11 oe", cpu_rdata_oe, rd);
    rdv = cpu_rdata;
    repeat (2) @(negedge clk);
    check("R9 ack held", cpu_ack_n, 0);
    release_bus();
    check("R11 oe off", cpu_rdata_oe, 0);
  endtask

  task automatic cpu_wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    cpu_xfer(1'b0, a, d, dummy);
  endtask

  task automatic dp_read(input logic [7:0] a, output logic [7:0] lo, output logic [7:0] hi);
    @(negedge clk);
    man_en = 1'b1; man_addr = a;
    @(negedge clk);
    man_en = 1'b0;
    check("R12 valid", dp_valid, 1);
    lo = dp_cm_lo; hi = dp_cm_hi;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rv, lo, hi;
    bit got;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ack", cpu_ack_n, 1);
    check("R1 oe", cpu_rdata_oe, 0);
    check("R1 force", proc_force, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cpu_xfer(1'b1, 6'h00, 8'h00, rv);
    check("R1 paging reset", rv, 8'h00);

    // R2 paging register
    cpu_wr(6'h00, 8'hA5);
    cpu_xfer(1'b1, 6'h1F, 8'h00, rv);
    check("R2 readback", rv, 8'hA5);
    check("R2 force low", proc_force, 0);
    cpu_wr(6'h00, 8'h40);
    check("R2 force high", proc_force, 1);
    cpu_wr(6'h00, 8'h00);
    check("R2 force clear", proc_force, 0);

    // R3 R4 R10: full sweep of both bytes with background datapath reads
    noise_en = 1'b1;
    for (int s = 0; s < 8; s++) begin
      cpu_wr(6'h00, pg(1'b0, 1'b0, 2'b10, s));
      for (int c = 0; c < 32; c++) cpu_wr(6'(32 + c), lo_val(s, c));
      cpu_wr(6'h00, pg(1'b0, 1'b0, 2'b11, s));
      for (int c = 0; c < 32; c++) cpu_wr(6'(32 + c), hi_val(s, c));
    end
    noise_en = 1'b0;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) begin
        dp_read(8'(s * 32 + c), lo, hi);
        check("R3 low byte", lo, lo_val(s, c));
        check("R4 high byte", hi, hi_val(s, c));
      end

    // R5 host readback
    cpu_wr(6'h00, pg(1'b0, 1'b0, 2'b11, 5));
    for (int c = 0; c < 32; c++) begin
      cpu_xfer(1'b1, 6'(32 + c), 8'h00, rv);
      check("R5 high read", rv, hi_val(5, c));
    end
    cpu_wr(6'h00, pg(1'b0, 1'b0, 2'b10, 2));
    for (int c = 0; c < 32; c += 3) begin
      cpu_xfer(1'b1, 6'(32 + c), 8'h00, rv);
      check("R5 low read", rv, lo_val(2, c));
    end

    // R6 data memory window
    cpu_wr(6'h00, pg(1'b0, 1'b0, 2'b00, 3));
    for (int c = 0; c < 32; c += 5) begin
      cpu_xfer(1'b1, 6'(32 + c), 8'h00, rv);
      check("R6 dm read", rv, dm_val(8'(3 * 32 + c)));
    end
    cpu_wr(6'(32 + 4), 8'hEE);
    cpu_wr(6'h00, pg(1'b0, 1'b0, 2'b01, 3));
    cpu_xfer(1'b1, 6'(32 + 7), 8'h00, rv);
    check("R6 sel01 read", rv, dm_val(8'(3 * 32 + 7)));
    cpu_wr(6'(32 + 4), 8'hDD);
    dp_read(8'(3 * 32 + 4), lo, hi);
    check("R6 write ignored lo", lo, lo_val(3, 4));
    check("R6 write ignored hi", hi, hi_val(3, 4));

    // R7 split mode
    cpu_wr(6'h00, pg(1'b1, 1'b0, 2'b10, 6));
    cpu_xfer(1'b1, 6'(32 + 9), 8'h00, rv);
    check("R7 split read", rv, dm_val(8'(6 * 32 + 9)));
    cpu_wr(6'(32 + 9), 8'h77);
    dp_read(8'(6 * 32 + 9), lo, hi);
    check("R7 split write lo", lo, 8'h77);
    check("R7 split keeps hi", hi, hi_val(6, 9));

    // R8 incomplete enables
    cpu_wr(6'h00, 8'h12);
    @(negedge clk);
    cpu_rw = 1'b0; cpu_addr = 6'h00; cpu_wdata = 8'hFF; cpu_cs_n = 1'b1; cpu_ds = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 no ack strobe only", cpu_ack_n, 1);
    cpu_ds = 1'b0; cpu_cs_n = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 no ack select only", cpu_ack_n, 1);
    cpu_cs_n = 1'b1;
    repeat (3) @(negedge clk);
    cpu_xfer(1'b1, 6'h00, 8'h00, rv);
    check("R8 paging kept", rv, 8'h12);

    // R10 host held off by continuous datapath reads
    cpu_wr(6'h00, pg(1'b0, 1'b0, 2'b10, 0));
    @(negedge clk);
    busy_all = 1'b1;
    cpu_rw = 1'b0; cpu_addr = 6'd32; cpu_wdata = 8'h99; cpu_cs_n = 1'b0; cpu_ds = 1'b1;
    repeat (40) @(negedge clk);
    check("R10 pending no ack", cpu_ack_n, 1);
    busy_all = 1'b0;
    wait_ack(got);
    check("R10 ack after free", got, 1);
    release_bus();
    dp_read(8'd0, lo, hi);
    check("R10 write landed", lo, 8'h99);
    check("R10 hi intact", hi, hi_val(0, 0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule